// File: doc/BRIEF.md
# Weighted Pipeline Code Reconstruction

This block turns the per-stage decisions of a pipelined converter into one output word. The converter has eleven 1.5-bit stages followed by a 2-bit flash quantiser. Textbook correction assumes that every interstage gain is exactly two, so it can shift each stage's digit by one bit and add. Here each stage instead carries a measured weight, ideally one half. Stage k's signed digit is scaled by the running product of the weights of stages 1 to k. This absorbs interstage gain that falls short of two, for example a gain near 1.9. The overlap of the 1.5-bit decisions still absorbs comparator offsets.

The stage codes arrive already aligned in time, one sample per clock with a valid strobe. A calibration engine elsewhere delivers a full weight vector with a one-cycle load strobe. The block does not recompute the running products per sample. It builds them once per load, in a small sequential engine, and then swaps the whole set into use between two samples. The weighted sum is rounded onto a 12-bit scale, saturated, and presented a fixed four cycles after the sample was taken.

Top module: `wpc_recon`

## Requirements
- R1: Stage k (1..11) takes its code from `codes_i[2k-1:2k-2]`, and the flash code is `codes_i[23:22]`. A stage code decodes as 00 to −1, 01 to 0, 10 to +1, and 11 to 0.
- R2: Weight k is unsigned Q0.16 in `wt_i[16k-1:16k-16]`. The running scales are P0 = 2^24 and Pk = floor(Pk−1 · wk / 2^16). The bank never holds a scale larger than the one before it.
- R3: The weighted sum is S = Σk dk·Pk + floor(P11·(2c−3)/4), where dk is the decoded digit of stage k and c is the flash code read as 0..3.
- R4: The output word is floor((S + 2^24 + 2^12) / 2^13).
- R5: A result below 0 is output as 0, and a result above 4095 is output as 4095.
- R6: A sample is accepted on every clock edge where `in_valid_i` is high. Its word appears with `out_valid_o` high exactly four edges later, counting the edge that took the sample. No output is marked valid for a cycle without a sample.
- R7: After reset `out_valid_o` stays low until the first sample arrives. The scale bank then holds the ideal set, in which every weight is 0.5, that is Pk = 2^(24−k).
- R8: A load sampled at edge t replaces the whole scale set at once. Samples taken at edges up to t+12 use only the previous set, and samples taken from edge t+13 on use only the new set.
- R9: A load arriving while the products of an earlier load are still being built abandons that build. Only the latest vector ever takes effect, 13 edges after its own load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Sample present on `codes_i` |
| codes_i | input | 24 | Eleven stage codes and the flash code, stage 1 in the low bits |
| wt_load_i | input | 1 | One-cycle strobe that captures `wt_i` |
| wt_i | input | 176 | Eleven Q0.16 weights, stage 1 in the low bits |
| out_valid_o | output | 1 | Output word is valid |
| out_code_o | output | 12 | Reconstructed, rounded and saturated word |

## Verification
The checker watches, on every cycle, the four-edge relation between `in_valid_i` and `out_valid_o`, the quiet output in the first cycles after reset, and the ordering of the active scale bank. It also checks clamping: a rounded value that is negative or above full scale must reach the output as 0 or 4095. The numeric value of each word is left to the bench scenarios, which compare it against an independently computed fixed-point reconstruction. These cover the digit decoding including the unused code, several weight sets, and streams with gaps. Only those scenarios can show that a reload switches exactly between samples 12 and 13 edges after the strobe, and that a second load supersedes a build still in progress.

// File: rtl/wpc_pkg.sv
// Shared types for the weighted pipeline code reconstruction.
// Assumes the 1.5-bit stage code convention 00/01/10 with 11 unused.
package wpc_pkg;

    typedef enum logic [1:0] {
        DIG_NEG  = 2'd0,
        DIG_ZERO = 2'd1,
        DIG_POS  = 2'd2
    } digit_t;

    // Map a raw 2-bit stage code onto a signed digit; the unused code is zero.
    function automatic digit_t decode_digit(input logic [1:0] code);
        case (code)
            2'b00:   return DIG_NEG;
            2'b10:   return DIG_POS;
            default: return DIG_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/wpc_scale_bank.sv
// Builds the running products of the stage weights, one per clock, after each
// load strobe. It then swaps the finished set into the active bank in a single cycle.
// Assumes each weight is unsigned Q0.16 and below 1.0. A new load restarts the build.
module wpc_scale_bank #(
    parameter int NSTG = 11,
    parameter int WW   = 16,
    parameter int SF   = 24
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          load_i,
    input  logic [NSTG*WW-1:0]            wt_i,
    output logic [NSTG-1:0][SF:0]         scale_o
);
    localparam int SW = SF + 1;
    localparam int IW = (NSTG > 1) ? $clog2(NSTG) : 1;
    localparam logic [SW-1:0] ONE = SW'(1) << SF;

    logic [NSTG-1:0][WW-1:0] wreg_q;
    logic [NSTG-1:0][SW-1:0] shadow_q;
    logic [NSTG-1:0][SW-1:0] active_q;
    logic [SW-1:0]           acc_q;
    logic [IW-1:0]           idx_q;
    logic                    busy_q;
    logic                    commit_q;
    logic [SW+WW-1:0]        mul;
    logic [SW-1:0]           next_p;

    // One step of the running product, truncated back to Q1.SF.
    always_comb begin
        mul    = acc_q * wreg_q[idx_q];
        next_p = mul[SW+WW-1:WW];
    end

    // Load capture, sequential product build and single-cycle bank swap.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wreg_q   <= '0;
            acc_q    <= ONE;
            idx_q    <= '0;
            busy_q   <= 1'b0;
            commit_q <= 1'b0;
            for (int k = 0; k < NSTG; k++) begin
                shadow_q[k] <= ONE >> (k + 1);
                active_q[k] <= ONE >> (k + 1);
            end
        end else begin
            commit_q <= 1'b0;
            if (load_i) begin
                wreg_q <= wt_i;
                acc_q  <= ONE;
                idx_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                shadow_q[idx_q] <= next_p;
                acc_q           <= next_p;
                if (idx_q == IW'(NSTG - 1)) begin
                    busy_q   <= 1'b0;
                    commit_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (commit_q) begin
                active_q <= shadow_q;
            end
        end
    end

    assign scale_o = active_q;

endmodule

// File: rtl/wpc_term_gen.sv
// First pipeline stage: turns each stage digit into a signed term of its
// running scale, and forms the flash term as floor(P_N*(2c-3)/4).
// Assumes the scales are stable for the cycle in which they are sampled.
module wpc_term_gen #(
    parameter int NSTG = 11,
    parameter int SF   = 24
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        valid_i,
    input  logic [2*(NSTG+1)-1:0]       codes_i,
    input  logic [NSTG-1:0][SF:0]       scale_i,
    output logic                        valid_o,
    output logic [NSTG:0][SF+3:0]       terms_o
);
    import wpc_pkg::*;

    localparam int TW = SF + 4;

    logic [NSTG:0][TW-1:0] terms_d;
    logic signed [TW-1:0]  fp;
    logic signed [TW-1:0]  fmul;

    // Signed digit times scale for every stage, plus the flash term.
    always_comb begin
        for (int k = 0; k < NSTG; k++) begin
            case (decode_digit(codes_i[2*k +: 2]))
                DIG_NEG: terms_d[k] = -TW'(scale_i[k]);
                DIG_POS: terms_d[k] = TW'(scale_i[k]);
                default: terms_d[k] = '0;
            endcase
        end
        fp = TW'(scale_i[NSTG-1]);
        case (codes_i[2*NSTG +: 2])
            2'd0:    fmul = -(fp + (fp <<< 1));
            2'd1:    fmul = -fp;
            2'd2:    fmul = fp;
            default: fmul = fp + (fp <<< 1);
        endcase
        terms_d[NSTG] = fmul >>> 2;
    end

    // Register the terms and the valid flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            valid_o <= 1'b0;
            terms_o <= '0;
        end else begin
            valid_o <= valid_i;
            terms_o <= terms_d;
        end
    end

endmodule

// File: rtl/wpc_accum.sv
// Second and third pipeline stages: the sum of all terms, then the offset to
// unipolar, the half-LSB rounding and the drop to the output scale.
// Assumes the sum fits in SF+8 signed bits.
module wpc_accum #(
    parameter int NSTG  = 11,
    parameter int SF    = 24,
    parameter int OUT_W = 12
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        valid_i,
    input  logic [NSTG:0][SF+3:0]       terms_i,
    output logic                        valid_o,
    output logic signed [SF+7:0]        rnd_o
);
    localparam int SUMW  = SF + 8;
    localparam int SHIFT = SF + 1 - OUT_W;
    localparam logic signed [SUMW-1:0] ONE_S  = SUMW'(1) <<< SF;
    localparam logic signed [SUMW-1:0] HALF_S = SUMW'(1) <<< (SHIFT - 1);

    logic signed [SUMW-1:0] sum_d;
    logic signed [SUMW-1:0] sum_q;
    logic                   sv_q;

    // Sign-extend and add every term.
    always_comb begin
        sum_d = '0;
        for (int k = 0; k <= NSTG; k++) begin
            sum_d = sum_d + SUMW'($signed(terms_i[k]));
        end
    end

    // Sum register, then offset, round and scale register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sv_q    <= 1'b0;
            sum_q   <= '0;
            valid_o <= 1'b0;
            rnd_o   <= '0;
        end else begin
            sv_q    <= valid_i;
            sum_q   <= sum_d;
            valid_o <= sv_q;
            rnd_o   <= (sum_q + ONE_S + HALF_S) >>> SHIFT;
        end
    end

endmodule

// File: rtl/wpc_sat.sv
// Last pipeline stage: clamps the rounded value into 0 .. 2^OUT_W-1.
// Assumes a signed input that may lie outside the output range.
module wpc_sat #(
    parameter int SUMW  = 32,
    parameter int OUT_W = 12
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     valid_i,
    input  logic signed [SUMW-1:0]   rnd_i,
    output logic                     valid_o,
    output logic [OUT_W-1:0]         code_o
);
    localparam logic signed [SUMW-1:0] MAX_S = (SUMW'(1) <<< OUT_W) - 1;

    // Clamp and register the output word.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            valid_o <= 1'b0;
            code_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (rnd_i[SUMW-1]) begin
                code_o <= '0;
            end else if (rnd_i > MAX_S) begin
                code_o <= '1;
            end else begin
                code_o <= rnd_i[OUT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/wpc_recon.sv
// Weighted reconstruction of pipelined-converter stage codes into one output word.
// It has a four-stage datapath, one sample per clock, and per-stage calibrated scales.
// Assumes the stage codes are time-aligned upstream.
module wpc_recon #(
    parameter int NSTG  = 11,
    parameter int WW    = 16,
    parameter int SF    = 24,
    parameter int OUT_W = 12
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     in_valid_i,
    input  logic [2*(NSTG+1)-1:0]    codes_i,
    input  logic                     wt_load_i,
    input  logic [NSTG*WW-1:0]       wt_i,
    output logic                     out_valid_o,
    output logic [OUT_W-1:0]         out_code_o
);
    localparam int TW   = SF + 4;
    localparam int SUMW = SF + 8;

    logic [NSTG-1:0][SF:0]   scale_w;
    logic [NSTG:0][TW-1:0]   terms_w;
    logic                    tv_w;
    logic signed [SUMW-1:0]  rnd_w;
    logic                    rv_w;

    wpc_scale_bank #(.NSTG(NSTG), .WW(WW), .SF(SF)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (wt_load_i),
        .wt_i    (wt_i),
        .scale_o (scale_w)
    );

    wpc_term_gen #(.NSTG(NSTG), .SF(SF)) u_terms (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (in_valid_i),
        .codes_i (codes_i),
        .scale_i (scale_w),
        .valid_o (tv_w),
        .terms_o (terms_w)
    );

    wpc_accum #(.NSTG(NSTG), .SF(SF), .OUT_W(OUT_W)) u_accum (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (tv_w),
        .terms_i (terms_w),
        .valid_o (rv_w),
        .rnd_o   (rnd_w)
    );

    wpc_sat #(.SUMW(SUMW), .OUT_W(OUT_W)) u_sat (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (rv_w),
        .rnd_i   (rnd_w),
        .valid_o (out_valid_o),
        .code_o  (out_code_o)
    );

endmodule

// File: rtl/wpc_recon_chk.sv
// Checker for wpc_recon: output timing, reset quiet period, clamping and scale
// ordering. It is attached to every wpc_recon instance by the bind below.
module wpc_recon_chk #(
    parameter int NSTG  = 11,
    parameter int SF    = 24,
    parameter int OUT_W = 12
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     in_valid_i,
    input logic                     out_valid_o,
    input logic [OUT_W-1:0]         out_code_o,
    input logic signed [SF+7:0]     rnd_i,
    input logic [NSTG-1:0][SF:0]    scale_i
);
    localparam int SUMW = SF + 8;
    localparam logic signed [SUMW-1:0] MAX_S = (SUMW'(1) <<< OUT_W) - 1;

    logic [2:0] since_q;

    // Count edges since reset release, saturating, to bound history lookups.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            since_q <= '0;
        end else if (since_q != 3'd7) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R6
    latency_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_q >= 3'd4) |-> (out_valid_o == $past(in_valid_i, 4)));

    // R7
    reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_q < 3'd4) |-> !out_valid_o);

    // R5
    clamp_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((since_q >= 3'd1) && $past(rnd_i[SUMW-1])) |-> (out_code_o == '0));

    // R5
    clamp_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((since_q >= 3'd1) && $past(!rnd_i[SUMW-1] && (rnd_i > MAX_S))) |-> (out_code_o == '1));

    genvar k;
    generate
        for (k = 1; k < NSTG; k++) begin : g_order
            // R2
            scale_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                scale_i[k] <= scale_i[k-1]);
        end
    endgenerate

endmodule

bind wpc_recon wpc_recon_chk #(.NSTG(NSTG), .SF(SF), .OUT_W(OUT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .out_valid_o (out_valid_o),
    .out_code_o  (out_code_o),
    .rnd_i       (rnd_w),
    .scale_i     (scale_w)
);

// File: tb/wpc_recon_tb_top.sv
`timescale 1ns/1ps
module wpc_recon_tb_top;
    localparam int NSTG  = 11;
    localparam int WW    = 16;
    localparam int OUT_W = 12;
    localparam int CW    = 2 * (NSTG + 1);
    localparam int WV    = NSTG * WW;
    localparam int SWAP  = NSTG + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [CW-1:0] codes = '0;
    logic wt_load = 1'b0;
    logic [WV-1:0] wt = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [WV-1:0] cur_w;
    logic [CW-1:0] s_codes [64];
    bit            s_val   [64];
    bit            s_load  [64];
    logic [WV-1:0] s_wt    [64];
    int            exp_c   [64];

    always #2.5 clk = ~clk;

    wpc_recon dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (in_valid),
        .codes_i     (codes),
        .wt_load_i   (wt_load),
        .wt_i        (wt),
        .out_valid_o (out_valid),
        .out_code_o  (out_code)
    );

    // Weight vector with weight k = base + step*k.
    function automatic logic [WV-1:0] mk_w(input int base, input int step);
        logic [WV-1:0] v;
        for (int k = 0; k < NSTG; k++) v[k*WW +: WW] = WW'(base + step * k);
        return v;
    endfunction

    // Code vector with every stage the same, plus a flash code.
    function automatic logic [CW-1:0] mk_all(input logic [1:0] st, input logic [1:0] fl);
        logic [CW-1:0] v;
        for (int k = 0; k < NSTG; k++) v[2*k +: 2] = st;
        v[2*NSTG +: 2] = fl;
        return v;
    endfunction

    // Deterministic varied code pattern using codes 00/01/10 for stages.
    function automatic logic [CW-1:0] gen(input int i, input int seed);
        logic [CW-1:0] v;
        for (int k = 0; k < NSTG; k++) v[2*k +: 2] = 2'((i * 7 + k * 5 + seed) % 3);
        v[2*NSTG +: 2] = 2'((i + seed) % 4);
        return v;
    endfunction

    // Expected output from the requirement formulas (R1..R5).
    function automatic int recon(input logic [CW-1:0] c, input logic [WV-1:0] w);
        longint p, s, f, r;
        p = longint'(1) <<< 24;
        s = 0;
        for (int k = 0; k < NSTG; k++) begin
            p = (p * longint'(w[k*WW +: WW])) >>> 16;
            if (c[2*k +: 2] == 2'b00) s = s - p;
            else if (c[2*k +: 2] == 2'b10) s = s + p;
        end
        case (c[2*NSTG +: 2])
            2'd0:    f = -3 * p;
            2'd1:    f = -p;
            2'd2:    f = p;
            default: f = 3 * p;
        endcase
        s = s + (f >>> 2);
        r = (s + (longint'(1) <<< 24) + (longint'(1) <<< 12)) >>> 13;
        if (r < 0) return 0;
        if (r > 4095) return 4095;
        return int'(r);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Drive n prepared samples and check each output four edges later (R6).
    task automatic play(input int n, input string req);
        for (int cyc = 0; cyc < n + 5; cyc++) begin
            @(negedge clk);
            if (cyc >= 4) begin
                check(out_valid == s_val[cyc-4], {req, " R6 valid"}, out_valid, s_val[cyc-4]);
                if (s_val[cyc-4])
                    check(out_code == OUT_W'(exp_c[cyc-4]), req, out_code, exp_c[cyc-4]);
            end
            if (cyc < n) begin
                in_valid = s_val[cyc];
                codes    = s_codes[cyc];
                wt_load  = s_load[cyc];
                wt       = s_wt[cyc];
            end else begin
                in_valid = 1'b0;
                wt_load  = 1'b0;
            end
        end
    endtask

    task automatic clear_slots();
        for (int i = 0; i < 64; i++) begin
            s_val[i] = 1'b0; s_load[i] = 1'b0; s_codes[i] = '0; s_wt[i] = '0; exp_c[i] = 0;
        end
    endtask

    // R7: quiet output through and after reset.
    task automatic t_reset();
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7 in reset", out_valid, 0);
        end
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7 after reset", out_valid, 0);
        end
    endtask

    // R3 R4 R7: ideal reset scales with fixed and varied patterns.
    task automatic t_ideal();
        clear_slots();
        s_codes[0] = mk_all(2'b01, 2'd2); exp_c[0] = 2048;
        s_codes[1] = mk_all(2'b01, 2'd1); exp_c[1] = 2048;
        s_codes[2] = mk_all(2'b01, 2'd1); s_codes[2][1:0] = 2'b10; exp_c[2] = 3072;
        s_codes[3] = mk_all(2'b01, 2'd1); s_codes[3][1:0] = 2'b00; exp_c[3] = 1024;
        s_codes[4] = mk_all(2'b00, 2'd0); exp_c[4] = 0;
        for (int i = 5; i < 12; i++) begin
            s_codes[i] = gen(i, 3);
            exp_c[i] = recon(s_codes[i], cur_w);
        end
        for (int i = 0; i < 12; i++) s_val[i] = 1'b1;
        play(12, "R3 R4 R7 ideal");
    endtask

    // R1: unused code 11 contributes nothing, same as 01.
    task automatic t_code11();
        clear_slots();
        s_codes[0] = gen(2, 1); s_codes[0][9:8] = 2'b11;
        s_codes[1] = gen(2, 1); s_codes[1][9:8] = 2'b01;
        s_codes[2] = mk_all(2'b11, 2'd2);
        s_codes[3] = gen(4, 2);
        for (int i = 0; i < 4; i++) begin
            s_val[i] = 1'b1;
            exp_c[i] = recon(s_codes[i], cur_w);
        end
        exp_c[2] = 2048;
        play(4, "R1 decode");
    endtask

    // R6: gaps in the input stream produce gaps at the output.
    task automatic t_gaps();
        clear_slots();
        for (int i = 0; i < 10; i++) begin
            s_val[i] = (i % 3) != 1;
            s_codes[i] = gen(i, 7);
            exp_c[i] = recon(s_codes[i], cur_w);
        end
        play(10, "R6 gaps");
    endtask

    // R2 R8: load during a stream; exact switch at 13 edges after load.
    task automatic t_load_atomic();
        logic [WV-1:0] nw;
        nw = mk_w(16'h8200, 16'h0180);
        clear_slots();
        for (int i = 0; i < 22; i++) begin
            s_val[i] = 1'b1;
            s_codes[i] = gen(i, 1);
            s_wt[i] = nw;
            s_load[i] = (i == 2);
            exp_c[i] = recon(s_codes[i], (i < 2 + SWAP) ? cur_w : nw);
        end
        play(22, "R2 R8 swap");
        cur_w = nw;
    endtask

    // R5: gains short of two push sums past both ends of the scale.
    task automatic t_sat();
        logic [WV-1:0] nw;
        nw = mk_w(16'h8CCD, 0);
        clear_slots();
        s_load[0] = 1'b1;
        s_wt[0] = nw;
        s_codes[14] = mk_all(2'b00, 2'd0); exp_c[14] = 0;
        s_codes[15] = mk_all(2'b10, 2'd3); exp_c[15] = 4095;
        s_codes[16] = gen(3, 5);           exp_c[16] = recon(s_codes[16], nw);
        s_codes[17] = mk_all(2'b01, 2'd0); exp_c[17] = recon(s_codes[17], nw);
        for (int i = 14; i < 18; i++) s_val[i] = 1'b1;
        play(18, "R5 clamp");
        cur_w = nw;
    endtask

    // R9: second load during the build abandons the first.
    task automatic t_reload();
        logic [WV-1:0] wa;
        logic [WV-1:0] wb;
        wa = mk_w(16'h7C00, -16'sh0040);
        wb = mk_w(16'h8400, 16'h0100);
        clear_slots();
        for (int i = 0; i < 26; i++) begin
            s_val[i] = 1'b1;
            s_codes[i] = gen(i, 4);
            s_load[i] = (i == 2) || (i == 5);
            s_wt[i] = (i == 2) ? wa : wb;
            exp_c[i] = recon(s_codes[i], (i < 5 + SWAP) ? cur_w : wb);
        end
        play(26, "R9 reload");
        cur_w = wb;
    endtask

    initial begin
        cur_w = mk_w(16'h8000, 0);
        t_reset();
        t_ideal();
        t_code11();
        t_gaps();
        t_load_atomic();
        t_sat();
        t_reload();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule